// File: doc/BRIEF.md
# SPI Flash Command Front-End

This block is the serial slave interface of a SPI NOR flash target. It watches the chip-select, serial clock, serial data and active-low hold pins through a synchronizer on the internal clock. For each transaction it gathers an 8-bit opcode and a 24-bit address, most significant bit first, and passes them to the internal execution logic as a one-cycle request. Input bits are taken on rising SCK edges.

For the two read opcodes, the block then fetches bytes one at a time over a pulse-and-sample byte interface. It sends them out on falling SCK edges. The single-line read uses the serial output alone. The dual read drives two bits per edge, using the serial output and a second line that was the serial input during the header.

A hold pause freezes all shift state without ending the transaction. During the pause the outputs float, and the block resumes from the same bit once it is released. SCK may idle low or high between transactions, which covers SPI modes 0 and 3.

Top module: `spi_flash_front`

## Requirements
- R1: While reset is asserted, both output enables, `cmd_valid` and `rd_req` are low.
- R2: The first 32 rising SCK edges after chip select falls shift in the opcode, then the address, both MSB first. After the 32nd edge, `cmd_valid` pulses for exactly one cycle, and `cmd_opcode`/`cmd_addr` hold the captured values.
- R3: While `cs_n` is high, SCK and SI activity has no effect. If `cs_n` rises before 32 bits have arrived, no request is issued and the next transaction starts again at bit 0.
- R4: For opcode `RD1_OP` (default 0x03), `so_out` carries each read byte MSB first. One bit changes per falling SCK edge, starting with the first falling edge after the address. `so_oe` is high and `io0_oe` stays low.
- R5: For opcode `RD2_OP` (default 0x3B), each falling edge launches two bits. `so_out` carries the higher bit of the pair and `io0_out` the lower one, so bits 7/6 go first. Both enables are high.
- R6: `rd_req` pulses for one cycle when a read command is accepted, and again after the last bit of each byte has been launched. `rd_data` is sampled in the cycle `rd_req` is high. A read of N full bytes therefore issues N+1 requests.
- R7: For any other opcode, the block still issues the request but never enables an output and never raises `rd_req`.
- R8: Within a few clock cycles of `cs_n` going high, `so_oe` and `io0_oe` are low.
- R9: A hold starts only when `hold_n` is low while chip select is active and SCK is low. While held, SCK edges and SI are ignored, and both enables are low.
- R10: A hold ends only when `hold_n` is high while SCK is low, even if `hold_n` rose while SCK was high. The SCK fall that ends it launches no bit, and shifting continues from the exact paused position.
- R11: R2 to R6 apply both with SCK idling low (mode 0) and with SCK idling high (mode 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, much faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si_in | input | 1 | Serial data in (I/O0 input) |
| hold_n | input | 1 | Pause request, active low |
| so_out | output | 1 | Serial data out / I/O1 value |
| so_oe | output | 1 | Drive enable for `so_out` |
| io0_out | output | 1 | I/O0 value in dual reads |
| io0_oe | output | 1 | Drive enable for `io0_out` |
| cmd_valid | output | 1 | One-cycle request strobe |
| cmd_opcode | output | 8 | Captured opcode |
| cmd_addr | output | ADDR_W | Captured address |
| rd_req | output | 1 | Read byte request pulse |
| rd_data | input | 8 | Read byte, sampled with `rd_req` |

## Verification
A bit counter that slips by one position shows up as a wrong `cmd_addr`, or as a missing `cmd_valid` pulse, by the end of the header. A serializer misalignment corrupts the first read byte on the very next falling edge. A hold that lets one SCK edge through, or releases on the wrong level of SCK, shifts every later bit of the transaction. That is visible on the first byte sampled after the pause. A stale enable after chip select rises is seen on `so_oe` within the synchronizer delay.

// File: rtl/spif_pkg.sv
package spif_pkg;
  localparam int BYTE_W = 8;
  localparam int OP_W   = 8;

  // bits remaining in the output byte after one falling edge
  function automatic logic [3:0] bits_after_launch(input logic [3:0] rem, input logic dual);
    return dual ? rem - 4'd2 : rem - 4'd1;
  endfunction

  function automatic logic op_is_read(input logic [OP_W-1:0] op,
                                      input logic [OP_W-1:0] op_single,
                                      input logic [OP_W-1:0] op_dual);
    return (op == op_single) || (op == op_dual);
  endfunction
endpackage

// File: rtl/spif_sync.sv
module spif_sync #(
  parameter int           STAGES = 2,
  parameter int           W      = 4,
  parameter logic [W-1:0] INIT   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] r;
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) r <= INIT;
        else        r <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) r <= INIT;
        else        r <= g_stage[g-1].r;
    end
  end
  assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/spif_hold.sv
module spif_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_act,
  input  logic sck_s,
  input  logic hold_s,
  output logic held
);
  // hold state may only change while SCK is low
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       held <= 1'b0;
    else if (!cs_act) held <= 1'b0;
    else if (!sck_s)  held <= ~hold_s;
endmodule

// File: rtl/spif_rx.sv
module spif_rx
  import spif_pkg::*;
#(
  parameter int              ADDR_W = 24,
  parameter logic [OP_W-1:0] RD1_OP = 8'h03,
  parameter logic [OP_W-1:0] RD2_OP = 8'h3B,
  localparam int             HDR_W  = OP_W + ADDR_W,
  localparam int             CNT_W  = $clog2(HDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              rise_ev,
  input  logic              si_s,
  output logic              cmd_valid,
  output logic [OP_W-1:0]   cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_rd,
  output logic              cmd_dual,
  output logic [CNT_W-1:0]  bit_cnt
);
  logic [HDR_W-1:0] sreg;
  logic [HDR_W-1:0] hdr_nxt;
  logic             hdr_done;

  assign hdr_nxt  = {sreg[HDR_W-2:0], si_s};
  assign hdr_done = (bit_cnt == CNT_W'(HDR_W - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sreg      <= '0;
      bit_cnt   <= '0;
      cmd_valid <= 1'b0;
      cmd_op    <= '0;
      cmd_addr  <= '0;
      cmd_rd    <= 1'b0;
      cmd_dual  <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      if (!cs_act) begin
        bit_cnt <= '0;
      end else if (rise_ev && bit_cnt != CNT_W'(HDR_W)) begin
        sreg    <= hdr_nxt;
        bit_cnt <= bit_cnt + 1'b1;
        if (hdr_done) begin
          cmd_valid <= 1'b1;
          cmd_op    <= hdr_nxt[HDR_W-1 -: OP_W];
          cmd_addr  <= hdr_nxt[ADDR_W-1:0];
          cmd_rd    <= op_is_read(hdr_nxt[HDR_W-1 -: OP_W], RD1_OP, RD2_OP);
          cmd_dual  <= (hdr_nxt[HDR_W-1 -: OP_W] == RD2_OP);
        end
      end
    end
endmodule

// File: rtl/spif_tx.sv
module spif_tx
  import spif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              fall_ev,
  input  logic              start,
  input  logic              dual_in,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              rd_req,
  output logic              active,
  output logic              dual,
  output logic              so_bit,
  output logic              io0_bit
);
  logic [BYTE_W-1:0] dout;
  logic [3:0]        rem;
  logic [3:0]        rem_nxt;

  assign rem_nxt = bits_after_launch(rem, dual);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_req  <= 1'b0;
      active  <= 1'b0;
      dual    <= 1'b0;
      dout    <= '0;
      rem     <= '0;
      so_bit  <= 1'b0;
      io0_bit <= 1'b0;
    end else if (!cs_act) begin
      rd_req <= 1'b0;
      active <= 1'b0;
      rem    <= '0;
    end else begin
      rd_req <= 1'b0;
      if (start) begin
        active <= 1'b1;
        dual   <= dual_in;
        rd_req <= 1'b1;
      end
      if (rd_req) begin
        dout <= rd_data;
        rem  <= 4'(BYTE_W);
      end else if (fall_ev && active && rem != 4'd0) begin
        so_bit <= dout[BYTE_W-1];
        if (dual) begin
          io0_bit <= dout[BYTE_W-2];
          dout    <= {dout[BYTE_W-3:0], 2'b00};
        end else begin
          dout    <= {dout[BYTE_W-2:0], 1'b0};
        end
        rem <= rem_nxt;
        if (rem_nxt == 4'd0) rd_req <= 1'b1;
      end
    end
endmodule

// File: rtl/spi_flash_front.sv
module spi_flash_front
  import spif_pkg::*;
#(
  parameter int              ADDR_W      = 24,
  parameter int              SYNC_STAGES = 2,
  parameter logic [OP_W-1:0] RD1_OP      = 8'h03,
  parameter logic [OP_W-1:0] RD2_OP      = 8'h3B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si_in,
  input  logic              hold_n,
  output logic              so_out,
  output logic              so_oe,
  output logic              io0_out,
  output logic              io0_oe,
  output logic              cmd_valid,
  output logic [OP_W-1:0]   cmd_opcode,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              rd_req,
  input  logic [BYTE_W-1:0] rd_data
);
  localparam int CNT_W = $clog2(OP_W + ADDR_W + 1);

  logic [3:0]       pins_s;
  logic             cs_act, sck_s, si_s, hold_s, sck_p;
  logic             held, rise_ev, fall_ev;
  logic             cmd_rd, cmd_dual, tx_active, tx_dual;
  logic [CNT_W-1:0] bit_cnt;

  spif_sync #(.STAGES(SYNC_STAGES), .W(4), .INIT(4'b1001)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sck, si_in, hold_n}), .q(pins_s));

  assign cs_act = ~pins_s[3];
  assign sck_s  = pins_s[2];
  assign si_s   = pins_s[1];
  assign hold_s = pins_s[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_p <= 1'b0;
    else        sck_p <= sck_s;

  spif_hold u_hold (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_s(sck_s), .hold_s(hold_s), .held(held));

  // edges only count inside a transaction and outside a hold
  assign rise_ev = cs_act & ~held &  sck_s & ~sck_p;
  assign fall_ev = cs_act & ~held & ~sck_s &  sck_p;

  spif_rx #(.ADDR_W(ADDR_W), .RD1_OP(RD1_OP), .RD2_OP(RD2_OP)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .rise_ev(rise_ev), .si_s(si_s),
    .cmd_valid(cmd_valid), .cmd_op(cmd_opcode), .cmd_addr(cmd_addr),
    .cmd_rd(cmd_rd), .cmd_dual(cmd_dual), .bit_cnt(bit_cnt));

  spif_tx u_tx (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .fall_ev(fall_ev),
    .start(cmd_valid & cmd_rd), .dual_in(cmd_dual), .rd_data(rd_data),
    .rd_req(rd_req), .active(tx_active), .dual(tx_dual),
    .so_bit(so_out), .io0_bit(io0_out));

  assign so_oe  = cs_act & ~held & tx_active;
  assign io0_oe = so_oe & tx_dual;
endmodule

// File: rtl/spi_flash_front_chk.sv
module spi_flash_front_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_act,
  input logic             held,
  input logic             sck_s,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             cmd_valid,
  input logic             rd_req,
  input logic             tx_active,
  input logic             so_oe,
  input logic             io0_oe
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> (!so_oe && !io0_oe)); // R8
  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R2
  AST_REQ_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> tx_active); // R6
  AST_DUAL_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    io0_oe |-> so_oe); // R5
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> (!so_oe && !io0_oe)); // R9
  AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> $past(cs_act && !sck_s)); // R9
  AST_HOLD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held) |-> $past(!sck_s || !cs_act)); // R10
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (held && cs_act) |=> $stable(bit_cnt)); // R10
endmodule

bind spi_flash_front spi_flash_front_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .held(held), .sck_s(sck_s),
  .bit_cnt(bit_cnt), .cmd_valid(cmd_valid), .rd_req(rd_req),
  .tx_active(tx_active), .so_oe(so_oe), .io0_oe(io0_oe));

// File: tb/spi_flash_front_tb.sv
`timescale 1ns/1ps
module spi_flash_front_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic        so_out, so_oe, io0_out, io0_oe, cmd_valid, rd_req;
  logic [7:0]  cmd_opcode, rd_data;
  logic [23:0] cmd_addr;

  int checks = 0, fails = 0;
  int rd_cnt = 0, cmd_cnt = 0;
  logic rd_clr = 1'b0;
  logic [7:0] rd_base = 8'h00;

  always #2.5 clk = ~clk;

  spi_flash_front u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si_in(si), .hold_n(hold_n),
    .so_out(so_out), .so_oe(so_oe), .io0_out(io0_out), .io0_oe(io0_oe),
    .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr),
    .rd_req(rd_req), .rd_data(rd_data));

  // byte provider: byte k of a transaction is rd_base + k
  always @(posedge clk) begin
    if (rd_clr) rd_cnt <= 0;
    else if (rd_req) rd_cnt <= rd_cnt + 1;
    if (cmd_valid) cmd_cnt <= cmd_cnt + 1;
  end
  assign rd_data = rd_base + rd_cnt[7:0];

  typedef struct packed {
    logic        m3;
    logic [7:0]  op;
    logic [23:0] addr;
    logic [3:0]  nb;
    logic [7:0]  base;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b0, 8'h03, 24'h012345, 4'd3, 8'hA0},
    '{1'b1, 8'h03, 24'hFEDCBA, 4'd2, 8'h5C},
    '{1'b0, 8'h3B, 24'h00F00F, 4'd3, 8'h3C},
    '{1'b1, 8'h3B, 24'h800001, 4'd2, 8'hC3},
    '{1'b0, 8'hD8, 24'h7A5A5A, 4'd2, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  task automatic open_tx(input logic m3);
    sck = m3; hold_n = 1'b1; half();
    rd_clr = 1'b1; @(negedge clk); rd_clr = 1'b0;
    cs_n = 1'b0; half();
  endtask

  task automatic close_tx(input logic m3);
    sck = m3; half();
    cs_n = 1'b1; half(); half();
  endtask

  task automatic bit_in(input logic b);
    sck = 1'b0; si = b; half();
    sck = 1'b1; half();
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    for (int i = 31; i > 31 - n; i--) bit_in(w[i]);
  endtask

  task automatic get_byte(input logic dual, output logic [7:0] b);
    b = '0;
    if (!dual) begin
      for (int i = 7; i >= 0; i--) begin
        sck = 1'b0; half();
        b[i] = so_out;
        if (i == 7) begin
          chk("R4 so_oe in single read", 32'(so_oe), 32'd1);
          chk("R4 io0_oe in single read", 32'(io0_oe), 32'd0);
        end
        sck = 1'b1; half();
      end
    end else begin
      for (int i = 3; i >= 0; i--) begin
        sck = 1'b0; half();
        b[2*i+1] = so_out;
        b[2*i]   = io0_out;
        if (i == 3) chk("R5 both enables in dual read", 32'({so_oe, io0_oe}), 32'd3);
        sck = 1'b1; half();
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [7:0] exp_b;
    int c0;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 so_oe in reset", 32'(so_oe), 32'd0);
    chk("R1 io0_oe in reset", 32'(io0_oe), 32'd0);
    chk("R1 cmd_valid in reset", 32'(cmd_valid), 32'd0);
    chk("R1 rd_req in reset", 32'(rd_req), 32'd0);
    rst_n = 1'b1; half();

    // R3: traffic with chip select high
    c0 = cmd_cnt;
    for (int i = 0; i < 40; i++) bit_in(i[0]);
    sck = 1'b0; half();
    chk("R3 no request while deselected", 32'(cmd_cnt), 32'(c0));
    chk("R8 so_oe while deselected", 32'(so_oe), 32'd0);

    // R3: partial header discarded
    open_tx(1'b0);
    send_bits(32'h03ABCDEF, 20);
    close_tx(1'b0);
    chk("R3 partial header gives no request", 32'(cmd_cnt), 32'(c0));

    // vector table
    for (int v = 0; v < 5; v++) begin
      logic rd;
      rd = (VECS[v].op == 8'h03) || (VECS[v].op == 8'h3B);
      rd_base = VECS[v].base;
      c0 = cmd_cnt;
      open_tx(VECS[v].m3);
      send_bits({VECS[v].op, VECS[v].addr}, 32);
      if (rd) begin
        for (int k = 0; k < int'(VECS[v].nb); k++) begin
          get_byte(VECS[v].op == 8'h3B, b);
          exp_b = VECS[v].base + 8'(k);
          chk(VECS[v].m3 ? "R11 mode3 read byte" :
              (VECS[v].op == 8'h3B ? "R5 dual read byte" : "R4 single read byte"),
              32'(b), 32'(exp_b));
        end
      end else begin
        for (int k = 0; k < 16; k++) begin
          sck = 1'b0; half();
          chk("R7 no drive for non-read", 32'({so_oe, io0_oe}), 32'd0);
          sck = 1'b1; half();
        end
      end
      chk(VECS[v].m3 ? "R11 mode3 one request" : "R2 one request", 32'(cmd_cnt), 32'(c0 + 1));
      chk("R2 opcode", 32'(cmd_opcode), 32'(VECS[v].op));
      chk(VECS[v].m3 ? "R11 mode3 address" : "R2 address", 32'(cmd_addr), 32'(VECS[v].addr));
      chk(rd ? "R6 byte request count" : "R7 no byte requests",
          32'(rd_cnt), rd ? 32'(VECS[v].nb) + 32'd1 : 32'd0);
      close_tx(VECS[v].m3);
      chk("R8 enables low after deselect", 32'({so_oe, io0_oe}), 32'd0);
    end

    // R9/R10: hold in the address phase
    rd_base = 8'h11;
    open_tx(1'b0);
    send_bits(32'h035A5A5A, 18);
    sck = 1'b0; half();
    hold_n = 1'b0; half();
    bit_in(1'b1); bit_in(1'b0); bit_in(1'b1);
    hold_n = 1'b1; half();
    for (int i = 13; i >= 0; i--) bit_in(32'h035A5A5A >> i);
    get_byte(1'b0, b);
    chk("R9 address intact across hold", 32'(cmd_addr), 32'h5A5A5A);
    chk("R10 data after hold in header", 32'(b), 32'h11);
    close_tx(1'b0);

    // R9/R10: hold in the data phase, released while SCK high then low
    rd_base = 8'h96;
    open_tx(1'b0);
    send_bits(32'h03000100, 32);
    get_byte(1'b0, b);
    chk("R4 first byte before hold", 32'(b), 32'h96);
    exp_b = 8'h97;
    b = '0;
    for (int i = 7; i >= 5; i--) begin
      sck = 1'b0; half(); b[i] = so_out; sck = 1'b1; half();
    end
    sck = 1'b0; half(); b[4] = so_out;
    hold_n = 1'b0; half();
    chk("R9 outputs off during hold", 32'({so_oe, io0_oe}), 32'd0);
    sck = 1'b1; half(); sck = 1'b0; half(); sck = 1'b1; half();
    hold_n = 1'b1; half();
    chk("R10 still held while SCK high", 32'(so_oe), 32'd0);
    sck = 1'b0; half();
    chk("R10 released with SCK low", 32'(so_oe), 32'd1);
    chk("R10 no bit launched on release", 32'(so_out), 32'(exp_b[4]));
    sck = 1'b1; half();
    for (int i = 3; i >= 0; i--) begin
      sck = 1'b0; half(); b[i] = so_out; sck = 1'b1; half();
    end
    chk("R10 byte resumed at paused bit", 32'(b), 32'(exp_b));
    close_tx(1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule